// File: doc/BRIEF.md
# H-Bridge Gate Control with Turn-On Dead Time

This block is the digital core of a full-bridge gate driver. It serves two half-bridges that work independently of each other. Each half has a low-side and a high-side command input, and it drives a low-side and a high-side gate enable output. The block makes sure the two switches of one half are never on together. Every turn-on is held back by a programmable dead time, counted in clock cycles. Turn-offs happen at once, with no dead time added.

When the low-side command is high, it wins over the high-side command. Because of this, holding a half's high-side command high puts that half into bistate drive. In bistate drive the low-side command alone switches the half: the low gate follows the command, the high gate follows its inverse, and there is a dead time at every edge. A disable input and an undervoltage flag each force every output low. When both are clear again, all low-side gates give a bootstrap refresh pulse of programmable width. Any high-side request waits until that pulse has ended and one dead time has passed.

All asynchronous inputs pass through a synchronizer chain before they reach the interlock logic. This chain is two stages deep by default. With the defaults, a command change shows at the outputs after three clock edges, plus the dead time on a turn-on.

Top module: `hbridge_gate_ctl`

## Requirements
- R1: The halves are independent. A command change on one half leaves both gate outputs of the other half unchanged in every cycle.
- R2: If a half's low and high commands are both high, its low gate turns on and its high gate stays low.
- R3: The low and high gates of one half are never high in the same cycle. A high gate rises only after its low gate has been low for more than dead_cycles_i cycles. A low gate rises only after its high gate has been low for at least one cycle.
- R4: A gate turns off on the third rising clock edge after its command input changes. The dead time does not delay a turn-off.
- R5: A gate whose opposite gate is already off turns on at edge 3 + D, where D is dead_cycles_i. If the opposite gate must first turn off, the gate turns on at edge 4 + D.
- R6: While a half's high command is held at 1, its low gate equals its low command and its high gate equals the inverse of its low command. Every transition follows R4 and R5.
- R7: Edge 3 after dis_i rises drives all gate outputs low. They stay low while dis_i is high, whatever the commands are.
- R8: uv_i has the same effect as dis_i.
- R9: When the last of dis_i and uv_i falls and refresh_cycles_i = W > 0, the low gate of every half is high for exactly W cycles, starting at edge 3. A pending high-side request turns on at edge 4 + W + D.
- R10: When W = 0 there is no refresh pulse, and a pending high-side request turns on at edge 3 + D after release.
- R11: While rst_n is low, all gate outputs are low, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_i | input | 1 | Global disable, asynchronous |
| uv_i | input | 1 | Undervoltage flag, asynchronous |
| lo_cmd_i | input | HALVES | Low-side commands, bit 0 = half A, bit 1 = half B |
| hi_cmd_i | input | HALVES | High-side commands, same bit order |
| dead_cycles_i | input | CNT_W | Turn-on dead time in clock cycles |
| refresh_cycles_i | input | CNT_W | Refresh pulse width in clock cycles, 0 = no pulse |
| lo_gate_o | output | HALVES | Low-side gate enables |
| hi_gate_o | output | HALVES | High-side gate enables |

## Verification
The bench uses the defaults: HALVES = 2, CNT_W = 16 and SYNC_STAGES = 2. It keeps the dead time small (0, 1, 3 and 6 cycles). This makes all sixteen from/to command transitions of each half quick to sweep, for every dead time. At each step the bench counts the exact edge at which each gate settles, and it compares that edge with 3, 3 + D or 4 + D. Disable and undervoltage releases are run with a 4-cycle refresh pulse and with no pulse at all, so the pulse width and the deferred high-side edge are both exposed. A long random command run then looks for any overlap within a half.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
   typedef struct packed {
      logic lo;
      logic hi;
   } hbg_pair_t;

   localparam int unsigned HBG_CNT_W_DEF = 16;
   localparam int unsigned HBG_SYNC_DEF  = 2;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("hbg_sync needs at least two stages");
      end
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[k] <= '0;
               else        stg[k] <= stg[k-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hbg_ontimer.sv
module hbg_ontimer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kill,
   input  logic             force_on,
   input  logic             force_off,
   input  logic             req,
   input  logic             block,
   input  logic [CNT_W-1:0] dead,
   output logic             gate
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         gate <= 1'b0;
      end else if (kill || force_off) begin
         cnt  <= '0;
         gate <= 1'b0;
      end else if (force_on) begin
         cnt  <= '0;
         gate <= !block;
      end else if (!req || block) begin
         cnt  <= '0;
         gate <= 1'b0;
      end else if (cnt >= dead) begin
         gate <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hbg_refresh.sv
module hbg_refresh #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             off,
   input  logic [CNT_W-1:0] width,
   output logic             act
);
   logic             off_q;
   logic [CNT_W-1:0] left;
   logic             rel;

   assign rel = off_q && !off && (width != '0);
   assign act = rel || (left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= 1'b0;
         left  <= '0;
      end else begin
         off_q <= off;
         if (off)              left <= '0;
         else if (rel)         left <= width - 1'b1;
         else if (left != '0)  left <= left - 1'b1;
      end
   end
endmodule

// File: rtl/hbg_half.sv
module hbg_half
   import hbg_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             off,
   input  logic             ref_act,
   input  hbg_pair_t        cmd,
   input  logic [CNT_W-1:0] dead,
   output hbg_pair_t        gate
);
   logic want_lo, want_hi;

   assign want_lo = cmd.lo;
   assign want_hi = cmd.hi && !cmd.lo;

   hbg_ontimer #(.CNT_W(CNT_W)) u_lo (
      .clk(clk), .rst_n(rst_n), .kill(off),
      .force_on(ref_act), .force_off(1'b0),
      .req(want_lo), .block(gate.hi), .dead(dead), .gate(gate.lo)
   );

   hbg_ontimer #(.CNT_W(CNT_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .kill(off),
      .force_on(1'b0), .force_off(ref_act),
      .req(want_hi), .block(gate.lo), .dead(dead), .gate(gate.hi)
   );
endmodule

// File: rtl/hbridge_gate_ctl.sv
module hbridge_gate_ctl
   import hbg_pkg::*;
#(
   parameter int unsigned HALVES      = 2,
   parameter int unsigned CNT_W       = HBG_CNT_W_DEF,
   parameter int unsigned SYNC_STAGES = HBG_SYNC_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dis_i,
   input  logic              uv_i,
   input  logic [HALVES-1:0] lo_cmd_i,
   input  logic [HALVES-1:0] hi_cmd_i,
   input  logic [CNT_W-1:0]  dead_cycles_i,
   input  logic [CNT_W-1:0]  refresh_cycles_i,
   output logic [HALVES-1:0] lo_gate_o,
   output logic [HALVES-1:0] hi_gate_o
);
   localparam int unsigned SYNC_W = 2*HALVES + 2;

   generate
      if (HALVES < 1) begin : g_bad_halves
         $error("hbridge_gate_ctl needs at least one half");
      end
      if (CNT_W < 2) begin : g_bad_width
         $error("hbridge_gate_ctl counter width too small");
      end
   endgenerate

   logic [SYNC_W-1:0] raw, synced;
   logic [HALVES-1:0] lo_s, hi_s;
   logic              dis_s, uv_s, off, ref_act;

   assign raw = {uv_i, dis_i, hi_cmd_i, lo_cmd_i};

   hbg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
   );

   assign lo_s  = synced[HALVES-1:0];
   assign hi_s  = synced[2*HALVES-1:HALVES];
   assign dis_s = synced[2*HALVES];
   assign uv_s  = synced[2*HALVES+1];
   assign off   = dis_s || uv_s;

   hbg_refresh #(.CNT_W(CNT_W)) u_ref (
      .clk(clk), .rst_n(rst_n), .off(off),
      .width(refresh_cycles_i), .act(ref_act)
   );

   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         hbg_pair_t cmd_h, gate_h;
         assign cmd_h.lo = lo_s[h];
         assign cmd_h.hi = hi_s[h];
         hbg_half #(.CNT_W(CNT_W)) u_half (
            .clk(clk), .rst_n(rst_n), .off(off), .ref_act(ref_act),
            .cmd(cmd_h), .dead(dead_cycles_i), .gate(gate_h)
         );
         assign lo_gate_o[h] = gate_h.lo;
         assign hi_gate_o[h] = gate_h.hi;
      end
   endgenerate
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk #(
   parameter int unsigned HALVES = 2,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dis_i,
   input logic              uv_i,
   input logic [HALVES-1:0] lo_cmd_i,
   input logic [CNT_W-1:0]  dead_cycles_i,
   input logic [HALVES-1:0] lo_gate_o,
   input logic [HALVES-1:0] hi_gate_o
);
   logic [1:0] since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            since <= '0;
      else if (since != 2'd3) since <= since + 2'd1;
   end

   AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_gate_o & hi_gate_o) == '0); // R3

   AST_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (since == 2'd3 && $past(dis_i || uv_i, 3)) |-> (lo_gate_o == '0 && hi_gate_o == '0)); // R7

   generate
      for (genvar i = 0; i < HALVES; i++) begin : g_h
         logic [CNT_W:0] lo_run, hi_run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_run <= '0;
               hi_run <= '0;
            end else begin
               if (lo_gate_o[i])      lo_run <= '0;
               else if (lo_run != '1) lo_run <= lo_run + 1'b1;
               if (hi_gate_o[i])      hi_run <= '0;
               else if (hi_run != '1) hi_run <= hi_run + 1'b1;
            end
         end

         AST_HI_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hi_gate_o[i]) |-> (lo_run > {1'b0, dead_cycles_i})); // R3

         AST_LO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lo_gate_o[i]) |-> (hi_run != '0)); // R3

         AST_LO_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
            (since == 2'd3 && $past(lo_cmd_i[i], 3)) |-> !hi_gate_o[i]); // R2
      end
   endgenerate
endmodule

bind hbridge_gate_ctl hbg_chk #(.HALVES(HALVES), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .uv_i(uv_i),
   .lo_cmd_i(lo_cmd_i), .dead_cycles_i(dead_cycles_i),
   .lo_gate_o(lo_gate_o), .hi_gate_o(hi_gate_o)
);

// File: tb/sim_hbridge_gate_ctl.sv
module sim_hbridge_gate_ctl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dis = 1'b0, uv = 1'b0;
   logic [1:0]  lo_cmd = '0, hi_cmd = '0;
   logic [15:0] dead = '0, refw = 16'd4;
   logic [1:0]  lo_g, hi_g;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbridge_gate_ctl u0 (
      .clk(clk), .rst_n(rst_n), .dis_i(dis), .uv_i(uv),
      .lo_cmd_i(lo_cmd), .hi_cmd_i(hi_cmd),
      .dead_cycles_i(dead), .refresh_cycles_i(refw),
      .lo_gate_o(lo_g), .hi_gate_o(hi_g)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // expected edge at which one gate reaches its final value
   function automatic int exp_edge(input bit from_v, input bit to_v, input bit opp_from, input int d);
      if (from_v == to_v) return 0;
      if (!to_v)          return 3;
      return opp_from ? 4 + d : 3 + d;
   endfunction

   task automatic trans(input int h, input bit lf, input bit hf, input bit lt, input bit ht, input int d);
      int  oth, last_l, last_h, other_bad, both;
      bit  l_from, h_from, l_to, h_to;
      logic o_l, o_h;
      string tl, th;
      oth = 1 - h;
      l_from = lf; h_from = hf & ~lf; l_to = lt; h_to = ht & ~lt;
      lo_cmd[h] = lf; hi_cmd[h] = hf;
      idle(2*d + 12);
      o_l = lo_g[oth]; o_h = hi_g[oth];
      lo_cmd[h] = lt; hi_cmd[h] = ht;
      last_l = -1; last_h = -1; other_bad = 0; both = 0;
      for (int n = 0; n <= d + 10; n++) begin
         if (n > 0) @(negedge clk);
         if (lo_g[h] != l_to) last_l = n;
         if (hi_g[h] != h_to) last_h = n;
         if (lo_g[oth] != o_l || hi_g[oth] != o_h) other_bad++;
         if (lo_g[h] && hi_g[h]) both++;
      end
      tl = l_to ? ((lt && ht) ? "R2" : "R5") : "R4";
      th = h_to ? "R5" : "R4";
      if (hf && ht) begin tl = "R6"; th = "R6"; end
      chk(tl, last_l + 1, exp_edge(l_from, l_to, h_from, d));
      chk(th, last_h + 1, exp_edge(h_from, h_to, l_from, d));
      chk("R1", other_bad, 0);
      chk("R3", both, 0);
   endtask

   task automatic off_test(input bit use_uv, input int d, input int w);
      int a_lo_cnt, a_lo_first, a_hi_first, b_lo_cnt, b_hi_cnt, bad;
      string t_off, t_ref;
      t_off = use_uv ? "R8" : "R7";
      t_ref = (w > 0) ? "R9" : "R10";
      dead = 16'(d); refw = 16'(w);
      lo_cmd = 2'b10; hi_cmd = 2'b01;
      idle(2*d + 12);
      chk("R5", {30'd0, lo_g, hi_g}, 32'b1001);
      if (use_uv) uv = 1'b1; else dis = 1'b1;
      idle(2);
      chk("R4", {30'd0, lo_g, hi_g}, 32'b1001);
      idle(1);
      chk(t_off, {30'd0, lo_g, hi_g}, 0);
      lo_cmd = 2'b00;
      bad = 0;
      for (int n = 0; n < 10; n++) begin
         @(negedge clk);
         if (lo_g != 2'b00 || hi_g != 2'b00) bad++;
         hi_cmd = (n % 2 == 0) ? 2'b11 : 2'b01;
      end
      hi_cmd = 2'b01;
      idle(4);
      chk(t_off, bad + int'(lo_g) + int'(hi_g), 0);
      if (use_uv) uv = 1'b0; else dis = 1'b0;
      a_lo_cnt = 0; a_lo_first = -1; a_hi_first = -1; b_lo_cnt = 0; b_hi_cnt = 0;
      for (int n = 0; n <= w + d + 12; n++) begin
         if (n > 0) @(negedge clk);
         if (lo_g[0]) begin a_lo_cnt++; if (a_lo_first < 0) a_lo_first = n; end
         if (hi_g[0] && a_hi_first < 0) a_hi_first = n;
         if (lo_g[1]) b_lo_cnt++;
         if (hi_g[1]) b_hi_cnt++;
      end
      chk(t_ref, a_lo_cnt, w);
      chk(t_ref, a_lo_first, (w > 0) ? 3 : -1);
      chk(t_ref, b_lo_cnt, w);
      chk(t_ref, b_hi_cnt, 0);
      chk(t_ref, a_hi_first, (w > 0) ? 4 + w + d : 3 + d);
      lo_cmd = '0; hi_cmd = '0;
      idle(2*d + 12);
   endtask

   initial begin
      int dl [4];
      int overlap;
      dl[0] = 0; dl[1] = 1; dl[2] = 3; dl[3] = 6;
      // R11: reset holds outputs low even with commands active
      lo_cmd = 2'b01; hi_cmd = 2'b10;
      idle(6);
      chk("R11", {30'd0, lo_g, hi_g}, 0);
      lo_cmd = '0; hi_cmd = '0;
      @(negedge clk);
      rst_n = 1'b1;
      idle(5);
      chk("R11", {30'd0, lo_g, hi_g}, 0);

      for (int di = 0; di < 4; di++) begin
         dead = 16'(dl[di]);
         for (int h = 0; h < 2; h++) begin
            lo_cmd = '0; hi_cmd = '0;
            hi_cmd[1-h] = 1'b1;
            for (int c = 0; c < 16; c++) begin
               trans(h, c[3], c[2], c[1], c[0], dl[di]);
            end
         end
         lo_cmd = '0; hi_cmd = '0;
         idle(2*dl[di] + 12);
      end

      off_test(1'b0, 3, 4);
      off_test(1'b1, 2, 0);
      off_test(1'b1, 0, 1);

      // R3: random commands with occasional disable
      dead = 16'd1; refw = 16'd2;
      overlap = 0;
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         if ((lo_g & hi_g) != 2'b00) overlap++;
         lo_cmd = 2'($urandom_range(0, 3));
         hi_cmd = 2'($urandom_range(0, 3));
         dis = ($urandom_range(0, 49) == 0);
      end
      dis = 1'b0;
      chk("R3", overlap, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R3 actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule